// File: doc/BRIEF.md
# Serial Port Register and Interrupt Front End

This block is the bus-facing half of a byte-oriented serial port. A host reaches it through a 256-byte register window on a simple 32-bit bus with per-lane byte enables. The window holds the control, enable, status, FIFO-control and bit-rate registers. Two small byte FIFOs sit behind a transmit data port and a receive data port. On the line side, outgoing and incoming bytes travel as valid/ready byte streams, so a separate bit-level shifter can be attached.

Two status flags report receive data present and transmit queue empty. Both are set from FIFO occupancy and then held until software clears them with an AND-style write. A level interrupt is raised while any held flag has its enable bit set. FIFO flushes are guarded: a flush request acts only when the flush-enable bit is also set in the value that results from the write.

Top module: `sio_ctrl_front`

## Requirements
- R1: While reset is active and just after it, line control reads 0x40000000 and bit-rate control reads 0x03FF0000. Every other register reads 0, both FIFOs are empty (tx_valid=0, rx_ready=1) and irq_o=0.
- R2: Every register write is masked, and a read returns the stored value. The masks are: line control (byte offset 0x00) 0xE17F0000, interrupt enable (0x08) 0x000F0000, FIFO control (0x10) 0x001F0000, bit-rate control (0x14) 0x03FF0000. Line status (0x04) and the receive port (0x30) ignore writes. Unmapped offsets ignore writes and read 0.
- R3: A write changes only the byte lanes whose bus_be bit is set. bus_be[3] selects bits 31:24 (byte offset 0, big-endian), and bus_be[0] selects bits 7:0.
- R4: A write to the transmit port (0x20) with bus_be[3] set pushes bus_wdata[31:24]. A write with bus_be[3] clear pushes nothing. Bytes leave on tx_data in push order, one per cycle in which tx_valid and tx_ready are both high. While tx_ready is low, tx_data holds.
- R5: A read of the receive port (0x30) with bus_be[3] set returns the oldest byte in bits 31:24 and pops it. If the FIFO is empty, or bus_be[3] is clear, the read returns 0 and nothing is popped. Reads of the transmit port return 0.
- R6: Status bit 16 (receive data) is set in the cycle after any cycle in which the receive FIFO holds a byte. It stays set after the FIFO drains.
- R7: Status bit 17 (transmit empty) is set in the cycle after any cycle in which the transmit FIFO is empty. It stays set after bytes are queued.
- R8: A write to the status register (0x0C) with bus_be[2] set ANDs bits 18:16 with bus_wdata[18:16]. A bus write never sets a flag. If the occupancy condition still holds, the flag sets again at once.
- R9: irq_o is high exactly while (status & enable) is nonzero over bits 18:16. The enable bits are 16 for receive data, 17 for transmit empty and 18 for error. irq_o follows a register or flag change from the next clock edge.
- R10: FIFO control bit 16 is the flush enable, bit 17 flushes the receive FIFO and bit 18 flushes the transmit FIFO. A flush happens only on a write whose resulting value has bit 16 set together with the request bit.
- R11: Each FIFO holds FIFO_DEPTH bytes (16 by default). A push into a full transmit FIFO is dropped. rx_ready is low while the receive FIFO is full.
- R12: Enable bit 19 is stored and read back but has no effect on irq_o. Status bit 18 (error) is never set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address within the window |
| bus_be | input | 4 | Byte-lane enables, bit 3 = bits 31:24 |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_o | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Line side takes the transmit byte |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Receive byte offered |
| rx_ready | output | 1 | Receive FIFO can accept |
| rx_data | input | 8 | Receive byte |

## Verification
The bench uses the default FIFO depth of 16. At that depth a seventeenth push is enough to reach the full-FIFO drop and the deasserted rx_ready, while staying within a short run. The 256-byte window width lets an unmapped offset at 0x40 be hit. A write-then-read vector table covers the mask and lane behaviour. Directed sequences then cover the interaction between flags, occupancy, clearing and the guarded flush, with each flag observed at the cycle after the occupancy change.

// File: rtl/sio_pkg.sv
package sio_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_LINE  = 8'h00;
  localparam logic [ADDR_W-1:0] OFF_LSTAT = 8'h04;
  localparam logic [ADDR_W-1:0] OFF_IEN   = 8'h08;
  localparam logic [ADDR_W-1:0] OFF_ISTAT = 8'h0C;
  localparam logic [ADDR_W-1:0] OFF_FCTL  = 8'h10;
  localparam logic [ADDR_W-1:0] OFF_RATE  = 8'h14;
  localparam logic [ADDR_W-1:0] OFF_TXP   = 8'h20;
  localparam logic [ADDR_W-1:0] OFF_RXP   = 8'h30;

  localparam logic [31:0] MASK_LINE = 32'hE17F_0000;
  localparam logic [31:0] MASK_IEN  = 32'h000F_0000;
  localparam logic [31:0] MASK_FCTL = 32'h001F_0000;
  localparam logic [31:0] MASK_RATE = 32'h03FF_0000;

  localparam logic [31:0] RST_LINE = 32'h4000_0000;
  localparam logic [31:0] RST_RATE = 32'h03FF_0000;

  localparam int FLAG_LSB   = 16;
  localparam int FLAG_N     = 3;
  localparam int FC_ENA     = 16;
  localparam int FC_RX_FLUSH = 17;
  localparam int FC_TX_FLUSH = 18;

  function automatic logic [31:0] lane_merge(input logic [31:0] old_v,
                                             input logic [31:0] new_v,
                                             input logic [3:0]  be,
                                             input logic [31:0] keep);
    logic [31:0] lm;
    for (int i = 0; i < 4; i++) lm[i*8 +: 8] = {8{be[i]}};
    return keep & ((old_v & ~lm) | (new_v & lm));
  endfunction
endpackage

// File: rtl/sio_byte_fifo.sv
module sio_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             empty,
  output logic             full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] rd_q, rd_d, wr_q, wr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CAP);
  assign dout  = mem[rd_q];

  always_comb begin
    push_ok = push && !full;
    pop_ok  = pop && !empty;
    rd_d    = pop_ok  ? bump(rd_q) : rd_q;
    wr_d    = push_ok ? bump(wr_q) : wr_q;
    cnt_d   = cnt_q + CNT_W'(push_ok) - CNT_W'(pop_ok);
    if (clr) begin
      rd_d  = '0;
      wr_d  = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      wr_q  <= wr_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !clr) mem[wr_q] <= din;
  end

  p_no_overflow_r11: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CAP);
  p_full_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !clr) |=> full);
  p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> empty);
endmodule

// File: rtl/sio_int_flags.sv
module sio_int_flags
  import sio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_we,
  input  logic [FLAG_N-1:0] st_keep,
  input  logic              rx_has_data,
  input  logic              tx_is_empty,
  input  logic [FLAG_N-1:0] ien,
  output logic [FLAG_N-1:0] flags,
  output logic              irq
);
  logic [FLAG_N-1:0] flags_q, flags_d, set_v, and_v;

  always_comb begin
    set_v   = {1'b0, tx_is_empty, rx_has_data};
    and_v   = st_we ? st_keep : '1;
    flags_d = (flags_q & and_v) | set_v;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;
  assign irq   = |(flags_q & ien);

  p_rx_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[0] && !st_we) |=> flags_q[0]);
  p_tx_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_q[1] && !st_we) |=> flags_q[1]);
  p_rx_no_bus_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_q[0] && !rx_has_data) |=> !flags_q[0]);
  p_tx_no_bus_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!flags_q[1] && !tx_is_empty) |=> !flags_q[1]);
  p_err_never_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !flags_q[2]);
endmodule

// File: rtl/sio_ctrl_front.sv
module sio_ctrl_front
  import sio_pkg::*;
#(
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [3:0]        bus_be,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq_o,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [7:0]        rx_data
);
  localparam int WORD_HI = ADDR_W - 1;

  logic [31:0] line_q, line_d, ien_q, ien_d, fctl_q, fctl_d, rate_q, rate_d;
  logic        wr, rd;
  logic        hit_line, hit_ien, hit_istat, hit_fctl, hit_rate, hit_txp, hit_rxp;
  logic        tx_push, tx_pop, tx_clr, tx_empty, tx_full;
  logic        rx_push, rx_pop, rx_clr, rx_empty, rx_full;
  logic [7:0]  rx_head;
  logic [FLAG_N-1:0] flags, st_keep;

  assign wr = bus_sel && bus_we;
  assign rd = bus_sel && !bus_we;

  assign hit_line  = bus_addr[WORD_HI:2] == OFF_LINE[WORD_HI:2];
  assign hit_ien   = bus_addr[WORD_HI:2] == OFF_IEN[WORD_HI:2];
  assign hit_istat = bus_addr[WORD_HI:2] == OFF_ISTAT[WORD_HI:2];
  assign hit_fctl  = bus_addr[WORD_HI:2] == OFF_FCTL[WORD_HI:2];
  assign hit_rate  = bus_addr[WORD_HI:2] == OFF_RATE[WORD_HI:2];
  assign hit_txp   = bus_addr[WORD_HI:2] == OFF_TXP[WORD_HI:2];
  assign hit_rxp   = bus_addr[WORD_HI:2] == OFF_RXP[WORD_HI:2];

  always_comb begin
    line_d = (wr && hit_line) ? lane_merge(line_q, bus_wdata, bus_be, MASK_LINE) : line_q;
    ien_d  = (wr && hit_ien)  ? lane_merge(ien_q,  bus_wdata, bus_be, MASK_IEN)  : ien_q;
    fctl_d = (wr && hit_fctl) ? lane_merge(fctl_q, bus_wdata, bus_be, MASK_FCTL) : fctl_q;
    rate_d = (wr && hit_rate) ? lane_merge(rate_q, bus_wdata, bus_be, MASK_RATE) : rate_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= RST_LINE;
      ien_q  <= '0;
      fctl_q <= '0;
      rate_q <= RST_RATE;
    end else begin
      line_q <= line_d;
      ien_q  <= ien_d;
      fctl_q <= fctl_d;
      rate_q <= rate_d;
    end
  end

  // Flushes act on the value the write leaves behind, not the old one.
  assign tx_clr  = wr && hit_fctl && fctl_d[FC_ENA] && fctl_d[FC_TX_FLUSH];
  assign rx_clr  = wr && hit_fctl && fctl_d[FC_ENA] && fctl_d[FC_RX_FLUSH];
  assign tx_push = wr && hit_txp && bus_be[3];
  assign tx_pop  = tx_valid && tx_ready;
  assign rx_push = rx_valid && rx_ready;
  assign rx_pop  = rd && hit_rxp && bus_be[3] && !rx_empty;
  assign tx_valid = !tx_empty;
  assign rx_ready = !rx_full;

  sio_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_tx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(tx_clr),
    .push(tx_push), .din(bus_wdata[31:24]),
    .pop(tx_pop), .dout(tx_data),
    .empty(tx_empty), .full(tx_full)
  );

  sio_byte_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_rx_fifo (
    .clk(clk), .rst_n(rst_n), .clr(rx_clr),
    .push(rx_push), .din(rx_data),
    .pop(rx_pop), .dout(rx_head),
    .empty(rx_empty), .full(rx_full)
  );

  assign st_keep = bus_be[2] ? bus_wdata[FLAG_LSB +: FLAG_N] : '1;

  sio_int_flags u_flags (
    .clk(clk), .rst_n(rst_n),
    .st_we(wr && hit_istat), .st_keep(st_keep),
    .rx_has_data(!rx_empty), .tx_is_empty(tx_empty),
    .ien(ien_q[FLAG_LSB +: FLAG_N]),
    .flags(flags), .irq(irq_o)
  );

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      if (hit_line)       bus_rdata = line_q;
      else if (hit_ien)   bus_rdata = ien_q;
      else if (hit_istat) bus_rdata = {13'd0, flags, 16'd0};
      else if (hit_fctl)  bus_rdata = fctl_q;
      else if (hit_rate)  bus_rdata = rate_q;
      else if (hit_rxp && bus_be[3] && !rx_empty) bus_rdata = {rx_head, 24'd0};
    end
  end

  p_tx_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_clr) |=> (tx_valid && $stable(tx_data)));
  p_flush_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && hit_fctl && !bus_wdata[FC_ENA] && bus_be[2] && tx_valid && !tx_ready) |=> tx_valid);
  p_rx_full_block_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !rx_pop && !rx_clr) |=> !rx_ready);
  p_irq_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (ien_q[FLAG_LSB +: FLAG_N] != '0));
endmodule

// File: tb/sio_ctrl_front_tb.sv
module sio_ctrl_front_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_we;
  logic [7:0]  bus_addr;
  logic [3:0]  bus_be;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_o, tx_valid, tx_ready, rx_valid, rx_ready;
  logic [7:0]  tx_data, rx_data;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_ctrl_front #(.FIFO_DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_o(irq_o), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
    .rx_ready(rx_ready), .rx_data(rx_data)
  );

  // {addr, be, wdata, expected readback}
  localparam logic [75:0] VEC [12] = '{
    {8'h00, 4'hF, 32'hFFFF_FFFF, 32'hE17F_0000},
    {8'h00, 4'h8, 32'h0000_0000, 32'h007F_0000},
    {8'h08, 4'hF, 32'hFFFF_FFFF, 32'h000F_0000},
    {8'h08, 4'h4, 32'h0005_0000, 32'h0005_0000},
    {8'h10, 4'hF, 32'h0000_0000, 32'h0000_0000},
    {8'h10, 4'hF, 32'hFFFF_FFFF, 32'h001F_0000},
    {8'h14, 4'hF, 32'h0000_0000, 32'h0000_0000},
    {8'h14, 4'h3, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h14, 4'h4, 32'hFFFF_FFFF, 32'h00FF_0000},
    {8'h04, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h40, 4'hF, 32'hFFFF_FFFF, 32'h0000_0000},
    {8'h20, 4'h0, 32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [3:0] be, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [3:0] be, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = be;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 1'b0;
  endtask

  task automatic peek(input logic [7:0] a, output logic [31:0] d);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a; bus_be = 4'hF;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic tx_take(input string req, input logic [7:0] exp);
    @(negedge clk);
    chk(req, {31'd0, tx_valid}, 32'd1);
    chk(req, {24'd0, tx_data}, {24'd0, exp});
    tx_ready = 1'b1;
    @(posedge clk);
    #1 tx_ready = 1'b0;
  endtask

  task automatic rx_give(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(posedge clk);
    #1 rx_valid = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_sel = 0; bus_we = 0; bus_addr = 0; bus_be = 0; bus_wdata = 0;
    tx_ready = 0; rx_valid = 0; rx_data = 0;
    repeat (2) @(negedge clk);

    // R1: reset values while reset is active
    peek(8'h00, d); chk("R1 line", d, 32'h4000_0000);
    peek(8'h14, d); chk("R1 rate", d, 32'h03FF_0000);
    peek(8'h08, d); chk("R1 ien", d, 32'h0);
    peek(8'h0C, d); chk("R1 istat", d, 32'h0);
    peek(8'h10, d); chk("R1 fctl", d, 32'h0);
    chk("R1 irq", {31'd0, irq_o}, 32'd0);
    chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
    chk("R1 rx_ready", {31'd0, rx_ready}, 32'd1);
    release_reset();

    // R2/R3 masks and lanes, table walk
    foreach (VEC[i]) begin
      bus_write(VEC[i][75:68], VEC[i][67:64], VEC[i][63:32]);
      bus_read(VEC[i][75:68], 4'hF, d);
      chk("R2 R3 table", d, VEC[i][31:0]);
    end
    bus_read(8'h30, 4'hF, d); chk("R5 rx empty read", d, 32'h0);

    do_reset(); release_reset();
    tick();
    // R7: tx empty flag set after reset
    bus_read(8'h0C, 4'hF, d); chk("R7 tx empty flag", d, 32'h0002_0000);
    chk("R9 irq off without enable", {31'd0, irq_o}, 32'd0);
    bus_write(8'h08, 4'hF, 32'h0002_0000);
    tick();
    chk("R9 irq on enable", {31'd0, irq_o}, 32'd1);
    // R8: bus cannot set, clear re-sets while condition holds
    bus_write(8'h0C, 4'hF, 32'hFFFF_FFFF);
    bus_read(8'h0C, 4'hF, d); chk("R8 no bus set R12 err", d, 32'h0002_0000);
    bus_write(8'h0C, 4'hF, 32'h0);
    bus_read(8'h0C, 4'hF, d); chk("R8 re-set while empty", d, 32'h0002_0000);

    // R4 transmit push and order
    bus_write(8'h20, 4'h8, 32'hA100_0000);
    bus_write(8'h20, 4'h7, 32'hEEEE_EEEE);
    bus_write(8'h20, 4'h8, 32'hB200_0000);
    bus_write(8'h20, 4'hF, 32'hC3FF_FFFF);
    tick();
    bus_read(8'h0C, 4'hF, d); chk("R7 sticky while queued", d, 32'h0002_0000);
    bus_read(8'h20, 4'h8, d); chk("R5 tx port reads zero", d, 32'h0);
    bus_write(8'h0C, 4'h4, 32'h0);
    tick();
    bus_read(8'h0C, 4'hF, d); chk("R8 clear", d, 32'h0);
    chk("R9 irq falls", {31'd0, irq_o}, 32'd0);
    tx_take("R4 first", 8'hA1);
    tx_take("R4 second", 8'hB2);
    tx_take("R4 third", 8'hC3);
    tick();
    chk("R4 drained", {31'd0, tx_valid}, 32'd0);
    tick();
    bus_read(8'h0C, 4'hF, d); chk("R7 re-set on empty", d, 32'h0002_0000);
    chk("R9 irq rises", {31'd0, irq_o}, 32'd1);

    // R5/R6 receive
    rx_give(8'h5A);
    rx_give(8'h6B);
    tick();
    bus_read(8'h0C, 4'hF, d); chk("R6 rx flag", d, 32'h0003_0000);
    bus_read(8'h30, 4'h4, d); chk("R5 other lane no pop", d, 32'h0);
    bus_read(8'h30, 4'h8, d); chk("R5 pop first", d, 32'h5A00_0000);
    bus_read(8'h30, 4'h8, d); chk("R5 pop second", d, 32'h6B00_0000);
    bus_read(8'h30, 4'h8, d); chk("R5 empty zero", d, 32'h0);
    bus_read(8'h0C, 4'hF, d); chk("R6 sticky after drain", d, 32'h0003_0000);
    bus_write(8'h0C, 4'h4, 32'hFFFE_FFFF);
    bus_read(8'h0C, 4'hF, d); chk("R8 clear rx only", d, 32'h0002_0000);

    // R10 guarded flush
    bus_write(8'h20, 4'h8, 32'h1100_0000);
    bus_write(8'h20, 4'h8, 32'h2200_0000);
    rx_give(8'h77);
    bus_write(8'h10, 4'h4, 32'h0006_0000);
    tick();
    chk("R10 tx kept without enable", {31'd0, tx_valid}, 32'd1);
    bus_write(8'h10, 4'h4, 32'h0005_0000);
    tick();
    chk("R10 tx flushed", {31'd0, tx_valid}, 32'd0);
    bus_read(8'h30, 4'h8, d); chk("R10 rx kept", d, 32'h7700_0000);
    rx_give(8'h78);
    bus_write(8'h10, 4'h4, 32'h0003_0000);
    bus_read(8'h30, 4'h8, d); chk("R10 rx flushed", d, 32'h0);

    // R11 full behaviour
    for (int i = 0; i <= DEPTH; i++) bus_write(8'h20, 4'h8, {i[7:0], 24'd0});
    for (int i = 0; i < DEPTH; i++) tx_take("R11 tx order", i[7:0]);
    tick();
    chk("R11 extra push dropped", {31'd0, tx_valid}, 32'd0);
    for (int i = 0; i < DEPTH; i++) rx_give(8'h80 + i[7:0]);
    tick();
    chk("R11 rx_ready low when full", {31'd0, rx_ready}, 32'd0);
    bus_read(8'h30, 4'h8, d); chk("R11 rx head", d, 32'h8000_0000);
    tick();
    chk("R11 rx_ready back", {31'd0, rx_ready}, 32'd1);

    // R12 DMA bit stored, no interrupt effect
    bus_write(8'h08, 4'hF, 32'h0008_0000);
    bus_read(8'h08, 4'hF, d); chk("R12 dma stored", d, 32'h0008_0000);
    tick();
    chk("R12 no irq", {31'd0, irq_o}, 32'd0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule